// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the processor side of a coprocessor port. For each coprocessor instruction it is given, it reads a two-bit response code from the coprocessor every cycle. From that code it decides whether to raise the undefined-instruction trap, hold the pipeline in a busy-wait, or let the instruction run. When the instruction runs, the block counts transfer cycles until the final one.

Toward the coprocessor the block drives a pass line. That line is high while the instruction is live and its condition holds. It drops when an interrupt breaks a busy-wait, so that the coprocessor does not commit and the instruction can be reissued later. For load/store-to-coprocessor instructions the block raises a memory request on each cycle in which a word moves. Instruction decode, the pipeline and interrupt vectoring are handled elsewhere.

An instruction is accepted in an idle cycle through a valid strobe. The handshake is first evaluated in the next cycle.

Top module: `cphs_sequencer`

## Requirements
- R1: After reset the block is idle, and stall, undefined-trap, pass, memory-request and done are all low.
- R2: The response codes are WAIT=2'b00, GO=2'b01, ABSENT=2'b10 and LAST=2'b11. ABSENT in an evaluation cycle of an instruction whose condition holds gives a one-cycle undefined-trap pulse in that same cycle, with no done. The block is idle in the next cycle.
- R3: WAIT in an evaluation cycle raises stall in that cycle and keeps the block evaluating, so the code is sampled again in the following cycle.
- R4: When WAIT is followed by ABSENT, the trap is taken in the ABSENT cycle.
- R5: When WAIT is followed by GO or LAST, the instruction proceeds without a trap.
- R6: An interrupt in an evaluation cycle that shows WAIT abandons the instruction. In the next cycle pass, stall, done and trap are all low, and the block is then idle.
- R7: Memory request is high in each cycle that shows GO or LAST for a load/store instruction whose condition holds. It is never high for a data-processing instruction.
- R8: Done is a one-cycle pulse in the cycle after LAST is seen.
- R9: An instruction whose condition fails keeps pass low, raises no stall, trap or memory request, and pulses done in the cycle after its evaluation cycle.
- R10: An instruction-valid strobe that arrives while an instruction is in progress is ignored.
- R11: Pass is high in every evaluation and transfer cycle of an instruction whose condition holds.
- R12: After GO has been seen, WAIT or ABSENT only stalls the transfer. Neither raises a trap, and an interrupt in that phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | A new coprocessor instruction is offered (taken only when idle) |
| instr_is_ls_i | input | 1 | 1: load/store-to-coprocessor, 0: data-processing |
| cond_ok_i | input | 1 | The instruction's condition holds |
| hs_code_i | input | 2 | Coprocessor response code |
| irq_i | input | 1 | Interrupt request |
| stall_o | output | 1 | Pipeline stall (busy-wait or held transfer) |
| undef_trap_o | output | 1 | Undefined-instruction trap pulse |
| cp_pass_o | output | 1 | Instruction live and allowed to commit |
| mem_req_o | output | 1 | Memory access request for a transfer word |
| done_o | output | 1 | Instruction completed pulse |

## Verification
The in-design properties check, on every cycle, several rules. A trap never coincides with done or a memory request. Done is a single pulse that follows LAST, and the number of transfer cycles agrees with the outcome. A stall always comes with pass. An interrupted busy-wait drops pass on the next cycle. A memory request only comes from a load/store instruction. Whether a whole sequence gives the right outputs can only be shown by the bench's scenarios. These include several waits before ABSENT or LAST, a multi-word transfer with stalls in the middle, failed conditions, and strobes that arrive mid-instruction. In those scenarios the bench compares each cycle against its own model.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

  typedef enum logic [1:0] {
    HS_WAIT   = 2'b00,
    HS_GO     = 2'b01,
    HS_ABSENT = 2'b10,
    HS_LAST   = 2'b11
  } hs_code_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EVAL   = 3'd1,
    ST_XFER   = 3'd2,
    ST_FINISH = 3'd3,
    ST_ABORT  = 3'd4
  } seq_state_e;

  // A word moves on GO and on LAST: both have bit 0 set.
  function automatic logic hs_moves(input logic [1:0] code);
    return code[0];
  endfunction

  function automatic logic hs_is_last(input logic [1:0] code);
    return code == HS_LAST;
  endfunction

  function automatic logic hs_is_wait(input logic [1:0] code);
    return code == HS_WAIT;
  endfunction

  function automatic logic hs_is_absent(input logic [1:0] code);
    return code == HS_ABSENT;
  endfunction

endpackage

// File: rtl/cphs_classify.sv
module cphs_classify
  import cphs_pkg::*;
(
  input  logic [1:0] hs_i,
  output logic       wait_o,
  output logic       absent_o,
  output logic       last_o,
  output logic       moves_o
);

  always_comb begin
    wait_o   = hs_is_wait(hs_i);
    absent_o = hs_is_absent(hs_i);
    last_o   = hs_is_last(hs_i);
    moves_o  = hs_moves(hs_i);
  end

endmodule

// File: rtl/cphs_beat_counter.sv
module cphs_beat_counter #(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              beat_i,
  output logic [BEAT_W-1:0] beats_o
);

  localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

  function automatic logic [BEAT_W-1:0] sat_inc(input logic [BEAT_W-1:0] v);
    return (v == BEAT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beats_o <= '0;
    else if (clear_i) beats_o <= '0;
    else if (beat_i)  beats_o <= sat_inc(beats_o);
  end

  // The count never wraps back to zero.
  assert_beat_nowrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && beats_o != '0) |=> beats_o != '0);

endmodule

// File: rtl/cphs_ctrl.sv
module cphs_ctrl
  import cphs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid_i,
  input  logic       instr_is_ls_i,
  input  logic       cond_ok_i,
  input  logic       irq_i,
  input  logic       hs_wait_i,
  input  logic       hs_absent_i,
  input  logic       hs_last_i,
  input  logic       hs_moves_i,
  output logic       evt_accept_o,
  output logic       evt_beat_o,
  output logic       is_ls_q_o,
  output logic       cond_q_o,
  output logic       stall_o,
  output logic       undef_trap_o,
  output logic       cp_pass_o,
  output logic       mem_req_o,
  output logic       done_o
);

  seq_state_e state_q, state_d;
  logic       is_ls_q, cond_q;
  logic       busy, engaged, in_eval, in_xfer;
  logic       evt_abort;

  assign in_eval = (state_q == ST_EVAL);
  assign in_xfer = (state_q == ST_XFER);
  assign busy    = in_eval | in_xfer;
  assign engaged = busy & cond_q;

  assign evt_accept_o = (state_q == ST_IDLE) & instr_valid_i;
  assign evt_abort    = in_eval & cond_q & hs_wait_i & irq_i;
  assign evt_beat_o   = engaged & hs_moves_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (instr_valid_i) state_d = ST_EVAL;
      ST_EVAL: begin
        if (!cond_q)          state_d = ST_FINISH;
        else if (hs_absent_i) state_d = ST_IDLE;
        else if (hs_wait_i)   state_d = irq_i ? ST_ABORT : ST_EVAL;
        else if (hs_last_i)   state_d = ST_FINISH;
        else                  state_d = ST_XFER;
      end
      ST_XFER:   if (hs_last_i) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      ST_ABORT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_ls_q <= 1'b0;
      cond_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (evt_accept_o) begin
        is_ls_q <= instr_is_ls_i;
        cond_q  <= cond_ok_i;
      end
    end
  end

  assign is_ls_q_o    = is_ls_q;
  assign cond_q_o     = cond_q;
  assign stall_o      = engaged & (hs_wait_i | (in_xfer & hs_absent_i));
  assign undef_trap_o = in_eval & cond_q & hs_absent_i;
  assign cp_pass_o    = engaged;
  assign mem_req_o    = evt_beat_o & is_ls_q;
  assign done_o       = (state_q == ST_FINISH);

  assert_abort_drops_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> (!cp_pass_o && !stall_o && !done_o && !undef_trap_o));

  assert_abort_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> ##1 (!cp_pass_o && !done_o));

  assert_trap_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap_o |-> (!done_o && !mem_req_o && !stall_o));

  assert_trap_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap_o |=> !undef_trap_o);

  assert_last_gives_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && hs_last_i) |=> done_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_stall_has_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> cp_pass_o);

  assert_mem_only_ls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> is_ls_q_o);

  assert_failed_cond_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_eval && !cond_q) |-> (!cp_pass_o && !stall_o && !undef_trap_o && !mem_req_o));

  assert_busy_ignores_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && instr_valid_i) |=> ($stable(is_ls_q) && $stable(cond_q)));

  assert_xfer_no_trap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_xfer |-> !undef_trap_o);

endmodule

// File: rtl/cphs_sequencer.sv
module cphs_sequencer #(
  parameter int BEAT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid_i,
  input  logic       instr_is_ls_i,
  input  logic       cond_ok_i,
  input  logic [1:0] hs_code_i,
  input  logic       irq_i,
  output logic       stall_o,
  output logic       undef_trap_o,
  output logic       cp_pass_o,
  output logic       mem_req_o,
  output logic       done_o
);

  logic              hs_wait, hs_absent, hs_last, hs_moves;
  logic              evt_accept, evt_beat;
  logic              is_ls_q, cond_q;
  logic [BEAT_W-1:0] beats;

  cphs_classify u_classify (
    .hs_i     (hs_code_i),
    .wait_o   (hs_wait),
    .absent_o (hs_absent),
    .last_o   (hs_last),
    .moves_o  (hs_moves)
  );

  cphs_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid_i (instr_valid_i),
    .instr_is_ls_i (instr_is_ls_i),
    .cond_ok_i     (cond_ok_i),
    .irq_i         (irq_i),
    .hs_wait_i     (hs_wait),
    .hs_absent_i   (hs_absent),
    .hs_last_i     (hs_last),
    .hs_moves_i    (hs_moves),
    .evt_accept_o  (evt_accept),
    .evt_beat_o    (evt_beat),
    .is_ls_q_o     (is_ls_q),
    .cond_q_o      (cond_q),
    .stall_o       (stall_o),
    .undef_trap_o  (undef_trap_o),
    .cp_pass_o     (cp_pass_o),
    .mem_req_o     (mem_req_o),
    .done_o        (done_o)
  );

  cphs_beat_counter #(.BEAT_W(BEAT_W)) u_beats (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (evt_accept),
    .beat_i  (evt_beat),
    .beats_o (beats)
  );

  // A completed instruction moved words exactly when its condition held.
  assert_done_beats_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((beats != '0) == cond_q));

  // A data-processing instruction never asks for memory, however many beats it ran.
  assert_cdp_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ls_q && beats != '0) |-> !mem_req_o);

endmodule

// File: tb/test_cphs_sequencer.sv
module test_cphs_sequencer;

  localparam logic [1:0] C_WAIT = 2'b00, C_GO = 2'b01, C_ABS = 2'b10, C_LAST = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid_i = 1'b0, instr_is_ls_i = 1'b0, cond_ok_i = 1'b0, irq_i = 1'b0;
  logic [1:0] hs_code_i = C_WAIT;
  logic       stall_o, undef_trap_o, cp_pass_o, mem_req_o, done_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  // Reference model: 0 idle, 1 evaluate, 2 transfer, 3 finish, 4 abort
  int   m_st = 0;
  logic m_ls = 1'b0, m_cond = 1'b0;

  cphs_sequencer i_cphs_sequencer (
    .clk, .rst_n, .instr_valid_i, .instr_is_ls_i, .cond_ok_i,
    .hs_code_i, .irq_i, .stall_o, .undef_trap_o, .cp_pass_o, .mem_req_o, .done_o
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  function automatic logic f_live(int st, logic c);
    return (st == 1 || st == 2) && c;
  endfunction

  function automatic logic f_stall(int st, logic c, logic [1:0] h);
    return f_live(st, c) && (h == C_WAIT || (st == 2 && h == C_ABS));
  endfunction

  function automatic logic f_trap(int st, logic c, logic [1:0] h);
    return st == 1 && c && h == C_ABS;
  endfunction

  function automatic logic f_mem(int st, logic c, logic ls, logic [1:0] h);
    return f_live(st, c) && ls && (h == C_GO || h == C_LAST);
  endfunction

  function automatic int f_next(int st, logic c, logic [1:0] h, logic v, logic irq);
    case (st)
      0: return v ? 1 : 0;
      1: begin
        if (!c) return 3;
        if (h == C_ABS) return 0;
        if (h == C_WAIT) return irq ? 4 : 1;
        if (h == C_LAST) return 3;
        return 2;
      end
      2: return (h == C_LAST) ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  // One cycle: drive at the falling edge, check mid-low phase, advance the model.
  task automatic cyc(logic v, logic ls, logic c, logic [1:0] h, logic irq, string tag);
    @(negedge clk);
    instr_valid_i = v; instr_is_ls_i = ls; cond_ok_i = c; hs_code_i = h; irq_i = irq;
    #5;
    chk(tag, "stall",   stall_o,      f_stall(m_st, m_cond, h));
    chk(tag, "trap",    undef_trap_o, f_trap(m_st, m_cond, h));
    chk(tag, "pass",    cp_pass_o,    f_live(m_st, m_cond));
    chk(tag, "mem_req", mem_req_o,    f_mem(m_st, m_cond, m_ls, h));
    chk(tag, "done",    done_o,       m_st == 3);
    if (m_st == 0 && v) begin
      m_ls = ls; m_cond = c;
    end
    m_st = f_next(m_st, m_cond, h, v, irq);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chk("R1", "stall", stall_o, 1'b0);
    chk("R1", "trap",  undef_trap_o, 1'b0);
    chk("R1", "pass",  cp_pass_o, 1'b0);
    chk("R1", "mem_req", mem_req_o, 1'b0);
    chk("R1", "done",  done_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: immediate ABSENT traps
    cyc(1, 0, 1, C_WAIT, 0, "R2");
    cyc(0, 0, 1, C_ABS,  0, "R2");
    cyc(0, 0, 0, C_WAIT, 0, "R2");

    // R3 and R4: two waits, then ABSENT
    cyc(1, 1, 1, C_WAIT, 0, "R3");
    cyc(0, 0, 0, C_WAIT, 0, "R3");
    cyc(0, 0, 0, C_WAIT, 0, "R3");
    cyc(0, 0, 0, C_ABS,  0, "R4");
    cyc(0, 0, 0, C_WAIT, 0, "R4");

    // R5, R7, R8, R12: a 4-word load/store, with a stall and an ignored interrupt in mid-transfer
    cyc(1, 1, 1, C_WAIT, 0, "R5");
    cyc(0, 0, 0, C_WAIT, 0, "R5");
    cyc(0, 0, 0, C_GO,   0, "R7");
    cyc(0, 0, 0, C_ABS,  1, "R12");
    cyc(0, 0, 0, C_WAIT, 1, "R12");
    cyc(0, 0, 0, C_GO,   0, "R7");
    cyc(1, 0, 0, C_GO,   0, "R10");
    cyc(0, 0, 0, C_LAST, 0, "R8");
    cyc(1, 0, 0, C_WAIT, 0, "R8");
    cyc(0, 0, 0, C_WAIT, 0, "R10");

    // R7: a data-processing instruction raises no memory request
    cyc(1, 0, 1, C_WAIT, 0, "R7");
    cyc(0, 0, 0, C_LAST, 0, "R7");
    cyc(0, 0, 0, C_WAIT, 0, "R8");

    // R6: interrupt during busy-wait
    cyc(1, 1, 1, C_WAIT, 0, "R6");
    cyc(0, 0, 0, C_WAIT, 1, "R6");
    cyc(1, 0, 0, C_GO,   0, "R6");
    cyc(0, 0, 0, C_LAST, 0, "R6");
    cyc(0, 0, 0, C_WAIT, 0, "R6");

    // R9: failed condition
    cyc(1, 1, 0, C_WAIT, 0, "R9");
    cyc(0, 0, 0, C_GO,   0, "R9");
    cyc(0, 0, 0, C_ABS,  0, "R9");
    cyc(0, 0, 0, C_WAIT, 0, "R9");

    // R11: pass is held through a single-word LAST after a wait
    cyc(1, 1, 1, C_WAIT, 0, "R11");
    cyc(0, 0, 0, C_WAIT, 0, "R11");
    cyc(0, 0, 0, C_LAST, 0, "R11");
    cyc(0, 0, 0, C_WAIT, 0, "R11");

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic       v, ls, c, irq;
      logic [1:0] h;
      v   = ($urandom % 3) == 0;
      ls  = $urandom % 2;
      c   = ($urandom % 5) != 0;
      h   = 2'($urandom % 4);
      irq = ($urandom % 8) == 0;
      cyc(v, ls, c, h, irq, "RND");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule